// File: doc/BRIEF.md
# Programmable Skew Clock Output Bank

This block generates four pairs of clock outputs from a fast timing clock whose period equals one skew time unit (tu). A free-running phase counter, stepped by the tu clock, defines a reference waveform with 50% duty. Each output pair taps that counter at its own delay, so a pair leads or lags a zero-skew position by whole tu steps. The zero-skew position sits a fixed base delay of 6 tu behind the reference, which leaves room for leads as well as lags.

Each pair is steered by a code of two three-level selects. Every select arrives already decoded as two bits. Pairs 1 and 2 move in single-tu steps. Pairs 3 and 4 move in double steps. On pairs 3 and 4 the two outer codes choose divided clocks instead, and on pair 4 one of them chooses an inverted clock. A range select sets how many tu make up one output period. A stop input parks the outputs, but pair 2 keeps running so it can serve as a feedback clock. An edge-polarity input picks which edge of the zero-skew clock the divided outputs follow. A test-mode input turns the stop into a per-pair disable. The integrator ties the selects to fixed levels and feeds the tu clock from an oscillator.

Top module: `skew_clock_bank`

## Requirements
- R1: Three-level values are encoded as 00 = low, 01 = mid, 10 = high. The output period P is 32, 16 or 8 tu for a range select of low, mid or high. After reset the reference output `ref_o` is high for the first P/2 cycles of each period. Its first high level appears one cycle after reset is released.
- R2: For pairs 1 and 2, the code index is k = 3*f1 + f0, where f1 is select bits [4p+3:4p+2] and f0 is bits [4p+1:4p] of pair index p (counting from 0), with low = 0, mid = 1, high = 2. The pair output equals `ref_o` delayed by 6 + (k - 4) cycles.
- R3: For pairs 3 and 4 with k from 1 to 7, the output equals `ref_o` delayed by 6 + 2*(k - 4) cycles.
- R4: With k = 0, pairs 3 and 4 output the clock divided by 2. With k = 8, pair 3 outputs the clock divided by 4 and pair 4 outputs the inverse of the zero-skew clock (`ref_o` delayed by 6).
- R5: Divided outputs change on the rising edges of the zero-skew clock when the edge control is 1 and on its falling edges when it is 0. The rising edges of the divide-by-2 and divide-by-4 outputs coincide.
- R6: A select value of 11 is treated as mid. Selects left at 11 give zero skew on every pair and a period of 16 tu.
- R7: While stop is 1 and test mode is not mid, pairs 1, 3 and 4 settle low and pair 2 keeps its normal waveform.
- R8: A stopped pair 4 in inverted mode is held at the level of the edge control.
- R9: While stop is 1 and test mode is mid, only pairs with k = 0 are held low, and the other pairs keep their normal waveforms. Test mode high behaves like test mode low.
- R10: A pair stops or restarts only while its waveform is at the parked level, so every high pulse of a zero-skew pair lasts exactly P/2 cycles.
- R11: Both outputs of a pair, `q_o[2p]` and `q_o[2p+1]`, are always identical.
- R12: While reset is asserted, `ref_o` and all of `q_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | tu timing clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| range_i | input | 2 | range select, three-level |
| sel_i | input | 16 | per-pair code, two three-level selects per pair |
| stop_i | input | 1 | synchronous output stop, active high |
| pe_i | input | 1 | edge polarity for divided outputs and inverted park level |
| test_i | input | 2 | test mode, three-level |
| ref_o | output | 1 | reference phase waveform |
| q_o | output | 8 | clock outputs, pair p on bits 2p and 2p+1 |

## Verification
The assertions take for granted that the range select holds steady between reset and any check of reference edges. They also assume that reset is held for at least one clock edge, so the counter step and gating properties start from a known previous cycle. The stimulus changes range, codes and edge polarity only while reset is held. Stop and test mode are toggled at falling clock edges on a running counter, and every sweep restarts from reset, so phase expectations always count from the release.

// File: rtl/skew_bank_pkg.sv
package skew_bank_pkg;

  typedef enum logic [1:0] {
    TRIT_L = 2'b00,
    TRIT_M = 2'b01,
    TRIT_H = 2'b10,
    TRIT_Z = 2'b11
  } trit_e;

  typedef enum logic [1:0] {
    MODE_SKEW = 2'd0,
    MODE_DIV2 = 2'd1,
    MODE_DIV4 = 2'd2,
    MODE_INV  = 2'd3
  } pair_mode_e;

  // undriven level reads as mid
  function automatic logic [1:0] trit_val(logic [1:0] t);
    return (trit_e'(t) == TRIT_Z) ? 2'd1 : t;
  endfunction

endpackage

// File: rtl/skew_phase_ctr.sv
module skew_phase_ctr #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // R1: phase advances exactly one tu per clock
  a_r1_ctr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/skew_tap_decode.sv
module skew_tap_decode
  import skew_bank_pkg::*;
#(
  parameter int unsigned BASE_DLY = 6,
  parameter int unsigned DLY_W    = 4,
  parameter bit          WIDE     = 1'b0,
  parameter bit          INV_TOP  = 1'b0
) (
  input  logic [3:0]       code_i,
  output pair_mode_e       mode_o,
  output logic [DLY_W-1:0] dly_o,
  output logic             ll_o
);

  int k;
  int sk;

  always_comb begin
    k      = 3 * int'(trit_val(code_i[3:2])) + int'(trit_val(code_i[1:0]));
    ll_o   = (k == 0);
    mode_o = MODE_SKEW;
    sk     = WIDE ? 2 * (k - 4) : (k - 4);
    if (WIDE && k == 0) mode_o = MODE_DIV2;
    if (WIDE && k == 8) mode_o = INV_TOP ? MODE_INV : MODE_DIV4;
    if (mode_o != MODE_SKEW) sk = 0;
    dly_o  = DLY_W'(int'(BASE_DLY) + sk);
  end

endmodule

// File: rtl/skew_pair_drv.sv
module skew_pair_drv
  import skew_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned DLY_W = 4,
  parameter bit          IS_FB = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] edge_i,
  input  pair_mode_e       mode_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             ll_i,
  input  logic             stop_i,
  input  logic             tmid_i,
  input  logic             pe_i,
  output logic             q_o
);

  logic [CNT_W-1:0] m1, m2, m4, half, ph, dd;
  logic             tap, raw, park, want, en_n, q_n;
  logic             en_q, q_q;

  always_comb begin
    m1   = per_i - CNT_W'(1);
    m2   = (per_i << 1) - CNT_W'(1);
    m4   = (per_i << 2) - CNT_W'(1);  // wraps to all ones at full width
    half = per_i >> 1;
    ph   = (cnt_i - CNT_W'(dly_i)) & m1;
    tap  = ph < half;
    dd   = cnt_i - edge_i;
    unique case (mode_i)
      MODE_SKEW: raw = tap;
      MODE_DIV2: raw = (dd & m2) < per_i;
      MODE_DIV4: raw = (dd & m4) < (per_i << 1);
      default:   raw = ~tap;
    endcase
    park = (mode_i == MODE_INV) & pe_i;
    if (stop_i && tmid_i) want = ~ll_i;
    else                  want = ~stop_i | IS_FB;
    // gate may only move while the waveform sits at the parked level
    en_n = (raw == park) ? want : en_q;
    q_n  = en_n ? raw : park;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b1;
      q_q  <= 1'b0;
    end else begin
      en_q <= en_n;
      q_q  <= q_n;
    end
  end

  assign q_o = q_q;

  // R10: a gate change lands while the output shows the parked level
  a_r10_gate_at_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && en_q != $past(en_q)) |-> q_q == $past(park));

  // R7: feedback pair is never gated off outside test-mode stop
  a_r7_fb_keeps_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (IS_FB && $past(rst_ni) && $past(en_q) && !$past(stop_i && tmid_i)) |-> en_q);

endmodule

// File: rtl/skew_clock_bank.sv
module skew_clock_bank
  import skew_bank_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned PER_LOG   = 5,
  parameter int unsigned BASE_DLY  = 6,
  parameter int unsigned FB_PAIR   = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             range_i,
  input  logic [4*NUM_PAIRS-1:0] sel_i,
  input  logic                   stop_i,
  input  logic                   pe_i,
  input  logic [1:0]             test_i,
  output logic                   ref_o,
  output logic [2*NUM_PAIRS-1:0] q_o
);

  localparam int unsigned CNT_W = PER_LOG + 2;
  localparam int unsigned DLY_W = $clog2(BASE_DLY + 2*4 + 1);

  logic [CNT_W-1:0] cnt, per, per_m1, half, edge_pt;
  logic [1:0]       rng;
  logic             tmid, ref_q;
  logic [NUM_PAIRS-1:0] pq;

  always_comb begin
    rng     = trit_val(range_i);
    per     = (CNT_W'(1) << PER_LOG) >> rng;
    per_m1  = per - CNT_W'(1);
    half    = per >> 1;
    edge_pt = CNT_W'(BASE_DLY) + (pe_i ? '0 : half);
    tmid    = (trit_val(test_i) == 2'd1);
  end

  skew_phase_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= (cnt & per_m1) < half;
  end
  assign ref_o = ref_q;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    pair_mode_e       mode;
    logic [DLY_W-1:0] dly;
    logic             ll;

    skew_tap_decode #(
      .BASE_DLY (BASE_DLY),
      .DLY_W    (DLY_W),
      .WIDE     (p >= 2),
      .INV_TOP  (p == NUM_PAIRS-1)
    ) i_dec (
      .code_i (sel_i[4*p +: 4]),
      .mode_o (mode),
      .dly_o  (dly),
      .ll_o   (ll)
    );

    skew_pair_drv #(
      .CNT_W (CNT_W),
      .DLY_W (DLY_W),
      .IS_FB (p == FB_PAIR)
    ) i_drv (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt),
      .per_i  (per),
      .edge_i (edge_pt),
      .mode_i (mode),
      .dly_i  (dly),
      .ll_i   (ll),
      .stop_i (stop_i),
      .tmid_i (tmid),
      .pe_i   (pe_i),
      .q_o    (pq[p])
    );

    assign q_o[2*p +: 2] = {2{pq[p]}};
  end

  // R1: reference rises only at the start of a period
  a_r1_ref_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $rose(ref_q) && $stable(range_i)) |->
      ((cnt - CNT_W'(1)) & per_m1) == '0);

endmodule

// File: tb/test_skew_clock_bank.sv
module test_skew_clock_bank;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  range_i = 2'b01;
  logic [1:0]  test_i = 2'b00;
  logic [15:0] sel_i = '0;
  logic        stop_i = 1'b0;
  logic        pe_i = 1'b1;
  logic        ref_o;
  logic [7:0]  q_o;

  int errs = 0;
  int chks = 0;
  int n = 0;
  int kk[4];
  int rc = 1;
  bit pe_b = 1'b1;
  bit ones_b = 1'b0;
  bit armed = 1'b0;
  int hlen = 0;

  always #10 clk_i = ~clk_i;

  skew_clock_bank i_skew_clock_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .range_i (range_i),
    .sel_i   (sel_i),
    .stop_i  (stop_i),
    .pe_i    (pe_i),
    .test_i  (test_i),
    .ref_o   (ref_o),
    .q_o     (q_o)
  );

  function automatic int per_of(int r);
    return (r == 0) ? 32 : ((r == 2) ? 8 : 16);
  endfunction

  function automatic logic [3:0] enc(int k);
    return {2'(k / 3), 2'(k % 3)};
  endfunction

  function automatic bit exp_ref(int t);
    int pp = per_of(rc);
    return (t % pp) < pp / 2;
  endfunction

  function automatic bit exp_pair(int p, int t);
    int pp = per_of(rc);
    int k = kk[p];
    int s, d, e;
    bit wide = (p >= 2);
    e = 6 + (pe_b ? 0 : pp / 2);
    d = (t - e + 1024) % (4 * pp);
    if (wide && k == 0) return (d % (2 * pp)) < pp;
    if (wide && k == 8) begin
      if (p == 2) return d < 2 * pp;
      return !(((t - 6 + 1024) % pp) < pp / 2);
    end
    s = wide ? 2 * (k - 4) : (k - 4);
    return ((t - 6 - s + 1024) % pp) < pp / 2;
  endfunction

  function automatic string tag_of(int p);
    if (p < 2) return "R2";
    if (kk[p] == 0 || kk[p] == 8) return pe_b ? "R4" : "R5";
    return "R3";
  endfunction

  task automatic chk(logic act, logic exp, string req);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s cycle=%0d actual=%b expected=%b", req, n, act, exp);
    end
  endtask

  task automatic apply();
    for (int p = 0; p < 4; p++) sel_i[4*p +: 4] = enc(kk[p]);
    if (ones_b) sel_i = '1;
    range_i = 2'(rc);
    pe_i = pe_b;
  endtask

  task automatic tick();
    @(posedge clk_i);
    n++;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    stop_i = 1'b0;
    test_i = 2'b00;
    apply();
    repeat (2) @(negedge clk_i);
    chk(ref_o, 1'b0, "R12");
    for (int b = 0; b < 8; b++) chk(q_o[b], 1'b0, "R12");
    rst_ni = 1'b1;
    n = 0;
  endtask

  task automatic check_all(int cyc, logic [3:0] msk, string req);
    for (int c = 0; c < cyc; c++) begin
      tick();
      chk(ref_o, exp_ref((n - 1) % 128), "R1");
      for (int p = 0; p < 4; p++) begin
        chk(q_o[2*p], q_o[2*p+1], "R11");
        if (msk[p]) chk(q_o[2*p], exp_pair(p, (n - 1) % 128),
                        (req == "") ? tag_of(p) : req);
      end
    end
  endtask

  task automatic hold_low(int cyc, logic [3:0] msk, string req);
    for (int c = 0; c < cyc; c++) begin
      tick();
      for (int p = 0; p < 4; p++) if (msk[p]) chk(q_o[2*p], 1'b0, req);
    end
  endtask

  // R10 monitor on pair 1 while gates move
  task automatic settle(int cyc);
    armed = 1'b0;
    hlen = 0;
    for (int c = 0; c < cyc; c++) begin
      tick();
      if (q_o[0]) begin
        if (armed) hlen++;
      end else begin
        if (armed && hlen > 0) chk(1'(hlen == per_of(rc) / 2), 1'b1, "R10");
        armed = 1'b1;
        hlen = 0;
      end
    end
  endtask

  task automatic stop_case(bit pe);
    rc = 2; pe_b = pe; ones_b = 0;
    kk[0] = 4; kk[1] = 4; kk[2] = 4; kk[3] = 8;
    do_reset();
    check_all(16, 4'hF, "");
    stop_i = 1'b1;
    settle(24);
    for (int c = 0; c < 16; c++) begin
      tick();
      chk(q_o[0], 1'b0, "R7");
      chk(q_o[4], 1'b0, "R7");
      chk(q_o[6], pe, "R8");
      chk(q_o[2], exp_pair(1, (n - 1) % 128), "R7");
      chk(q_o[6], q_o[7], "R11");
    end
    stop_i = 1'b0;
    settle(24);
    check_all(32, 4'hF, "R10");
  endtask

  initial begin
    #(200000 * 20);
    errs++;
    chks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    // sweep every code on every range and polarity
    for (int r = 0; r < 3; r++) begin
      for (int e = 0; e < 2; e++) begin
        for (int k = 0; k < 9; k++) begin
          rc = r; pe_b = e[0]; ones_b = 0;
          for (int p = 0; p < 4; p++) kk[p] = k;
          do_reset();
          check_all(5 * per_of(r) + 2, 4'hF, "");
        end
      end
    end

    // R6: undriven selects read as mid
    rc = 3; pe_b = 1; ones_b = 1;
    for (int p = 0; p < 4; p++) kk[p] = 4;
    do_reset();
    check_all(40, 4'hF, "R6");
    ones_b = 0;

    // R5: divide-by-4 on pair 3 against divide-by-2 on pair 4
    for (int e = 0; e < 2; e++) begin
      rc = 1; pe_b = e[0];
      kk[0] = 4; kk[1] = 4; kk[2] = 8; kk[3] = 0;
      do_reset();
      check_all(80, 4'hF, "R5");
    end

    stop_case(1'b1);
    stop_case(1'b0);

    // R9: test mode mid turns the stop into a per-pair disable
    rc = 2; pe_b = 1;
    kk[0] = 0; kk[1] = 4; kk[2] = 0; kk[3] = 5;
    do_reset();
    check_all(16, 4'hF, "");
    test_i = 2'b01;
    stop_i = 1'b1;
    settle(24);
    for (int c = 0; c < 16; c++) begin
      tick();
      chk(q_o[0], 1'b0, "R9");
      chk(q_o[4], 1'b0, "R9");
      chk(q_o[2], exp_pair(1, (n - 1) % 128), "R9");
      chk(q_o[6], exp_pair(3, (n - 1) % 128), "R9");
    end
    // R9: test mode high acts as normal stop
    test_i = 2'b10;
    settle(24);
    hold_low(8, 4'b1101, "R9");
    for (int c = 0; c < 8; c++) begin
      tick();
      chk(q_o[2], exp_pair(1, (n - 1) % 128), "R9");
    end

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

endmodule